// File: doc/BRIEF.md
# Vector Mask Population Count and Find-First Unit

This unit reduces one mask register to a single scalar. Software supplies a source mask, an optional execution mask, a vector length `vl` and a start index `vstart`. The element indices that take part are those from `vstart` up to, but not including, `vl`, and each of them must also be enabled by the execution mask. In count mode the unit returns how many of these active elements have their source bit set. In find-first mode it returns the lowest such index. If no active element has its source bit set, it returns an XLEN-wide word of all ones, which is minus one.

The operation starts with a one-cycle `start` pulse while the unit is idle. The unit copies both masks and the window bounds on that edge. It then scans one element per cycle. A find-first scan stops as soon as it finds a hit. When the scan finishes, the unit raises `done` for one cycle with the result. In the same cycle it pulses `vstate_upd`, which the surrounding pipeline uses to clear `vstart` and to mark the vector state dirty.

Top module: `vmask_reduce`

## Requirements
- R1: Only element indices i with vstart <= i < vl take part. Set source bits outside that window never add to the count and are never reported as the first hit.
- R2: When `vm` = 0, bit i of `v0` enables element i. A disabled element neither counts nor can be reported as the first hit.
- R3: With `mode` = 0 (count), `result` equals the number of active elements whose source bit is 1, zero-extended to XLEN.
- R4: With `mode` = 1 (find-first), `result` is the smallest active index whose source bit is 1, zero-extended to XLEN.
- R5: In find-first mode, when no active source bit is set, every bit of `result` is 1.
- R6: When `vm` = 1, every element in the window is active and `v0` has no effect on the result.
- R7: When vl equals vstart, count mode returns 0 and find-first mode returns all ones.
- R8: `done` is high for exactly one cycle per accepted start. `vstate_upd` is high in that same cycle and at no other time. `result` holds its value while `done` is low.
- R9: `src`, `v0`, `vm`, `mode`, `vl` and `vstart` are sampled on the edge that accepts `start`. Changes to them while `busy` is high do not affect the result.
- R10: `start` is ignored while `busy` is high. Each accepted start produces exactly one `done`, and `done` arrives no later than vl - vstart + 1 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| mode | input | 1 | 0 = count, 1 = find-first |
| vm | input | 1 | 1 = no execution mask, 0 = use `v0` |
| src | input | VLEN | Source mask register |
| v0 | input | VLEN | Execution mask register |
| vl | input | $clog2(VLEN+1) | Vector length (end of window, exclusive) |
| vstart | input | $clog2(VLEN+1) | First element of the window |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse; `result` is valid |
| result | output | XLEN | Count, index, or all ones |
| vstate_upd | output | 1 | Pulse: clear vstart and mark vector state dirty |

## Verification
A corrupted scan index or window bound shows up directly in the result. The count is off, or a hit outside the window is reported, on the very `done` that ends the affected operation. A stuck or lost busy state shows up as a missing `done` or as a second `done`. Both are visible within vl - vstart + 1 cycles of the start. During every scan the bench scrambles the inputs and toggles `start`, so a design that re-samples its inputs, or that accepts a new start mid-scan, gives a wrong value in that same operation.

// File: rtl/vmask_reduce.sv
module vmask_reduce #(
  parameter int VLEN = 64,
  parameter int XLEN = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       mode,
  input  logic                       vm,
  input  logic [VLEN-1:0]            src,
  input  logic [VLEN-1:0]            v0,
  input  logic [$clog2(VLEN+1)-1:0]  vl,
  input  logic [$clog2(VLEN+1)-1:0]  vstart,
  output logic                       busy,
  output logic                       done,
  output logic [XLEN-1:0]            result,
  output logic                       vstate_upd
);
  localparam int CW = $clog2(VLEN+1);
  localparam int IW = (VLEN > 1) ? $clog2(VLEN) : 1;

  logic [VLEN-1:0] src_q, act_q;
  logic [CW-1:0]   idx, end_q, beg_q, cnt, pos;
  logic            find_q, hit_seen;

  wire at_end = (idx >= end_q) || (find_q && hit_seen);
  wire hit    = src_q[idx[IW-1:0]] & act_q[idx[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; result <= '0;
      src_q <= '0; act_q <= '0; idx <= '0; end_q <= '0; beg_q <= '0;
      cnt <= '0; pos <= '0; find_q <= 1'b0; hit_seen <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          src_q <= src;
          act_q <= vm ? '1 : v0;
          idx <= vstart; beg_q <= vstart; end_q <= vl;
          find_q <= mode; cnt <= '0; pos <= '0; hit_seen <= 1'b0;
        end
      end else if (at_end) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (!find_q)       result <= XLEN'(cnt);
        else if (hit_seen) result <= XLEN'(pos);
        else               result <= '1;
      end else begin
        idx <= idx + 1'b1;
        if (hit) begin
          cnt <= cnt + 1'b1;
          if (!hit_seen) begin
            hit_seen <= 1'b1;
            pos <= idx;
          end
        end
      end
    end
  end

  assign vstate_upd = done;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R10
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R1
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && find_q && result != '1) |-> (result < XLEN'(end_q) && result >= XLEN'(beg_q)));
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !find_q) |-> (result <= XLEN'(end_q)));
endmodule

// File: tb/tb_vmask_reduce.sv
module tb_vmask_reduce;
  localparam int VLEN = 64;
  localparam int XLEN = 32;
  localparam int CW = $clog2(VLEN+1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0, vm = 1'b1;
  logic [VLEN-1:0] src = '0, v0 = '0;
  logic [CW-1:0] vl = '0, vstart = '0;
  logic busy, done, vstate_upd;
  logic [XLEN-1:0] result;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  vmask_reduce #(.VLEN(VLEN), .XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vm(vm),
    .src(src), .v0(v0), .vl(vl), .vstart(vstart),
    .busy(busy), .done(done), .result(result), .vstate_upd(vstate_upd));

  function automatic logic [XLEN-1:0] model(input logic md, input logic m,
      input logic [VLEN-1:0] s, input logic [VLEN-1:0] e, input int l, input int b);
    int c = 0;
    for (int i = b; i < l; i++)
      if (s[i] && (m || e[i])) begin
        if (md) return XLEN'(i);
        c++;
      end
    return md ? '1 : XLEN'(c);
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic md, input logic m,
      input logic [VLEN-1:0] s, input logic [VLEN-1:0] e, input int l, input int b);
    logic [XLEN-1:0] exp = model(md, m, s, e, l, b);
    int lat = 0;
    @(negedge clk);
    mode = md; vm = m; src = s; v0 = e; vl = CW'(l); vstart = CW'(b); start = 1'b1;
    @(negedge clk);
    // R9 R10: scramble inputs and poke start while busy
    while (!done && lat < 200) begin
      src = {$urandom, $urandom}; v0 = {$urandom, $urandom};
      mode = 1'($urandom); vm = 1'($urandom);
      vl = CW'($urandom_range(VLEN, 0)); vstart = '0;
      start = 1'($urandom);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({req, " R10 latency"}, XLEN'(lat <= l - b + 1), 1);
    check({req, " result"}, result, exp);
    check("R8 vstate_upd with done", XLEN'(vstate_upd), 1);
    @(negedge clk);
    check("R8 single done", XLEN'({done, vstate_upd}), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R8 reset done", XLEN'({done, busy, vstate_upd}), 0);
    check("R8 reset result", result, 0);
    rst_n = 1'b1;
    // directed corner cases
    run("R7 empty count", 0, 1, '1, '1, 10, 10);
    run("R7 empty find", 1, 1, '1, '1, 10, 10);
    run("R5 none found", 1, 1, '0, '1, 64, 0);
    run("R1 below window", 0, 1, 64'h0000_0000_0000_00FF, '0, 64, 8);
    run("R1 at vl excluded", 1, 1, 64'h1 << 20, '0, 20, 0);
    run("R4 last index", 1, 1, 64'h8000_0000_0000_0000, '0, 64, 0);
    run("R4 first index", 1, 1, 64'h1, '0, 64, 0);
    run("R3 full count", 0, 1, '1, '0, 64, 0);
    run("R2 masked first skipped", 1, 0, 64'h0000_0000_0000_0006, 64'h4, 64, 0);
    run("R2 all disabled", 0, 0, '1, '0, 64, 0);
    run("R6 vm ignores v0", 0, 1, 64'hF0F0, '0, 16, 0);
    run("R4 window start hit", 1, 1, 64'hFFFF, '0, 30, 5);
    for (int k = 0; k < 300; k++) begin
      int l = $urandom_range(VLEN, 0);
      int b = $urandom_range(l, 0);
      run("R3 R4 random", 1'($urandom), 1'($urandom), {$urandom, $urandom},
          {$urandom, $urandom}, l, b);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule